// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM with Flow-Through Read

This block models a synchronous static RAM whose data phase runs one clock behind its command phase. At a rising edge, while the clock enable is active, the block captures an address, a read/write direction and per-lane write strobes. The data for that command moves during the next cycle. Write data is registered at the edge that closes that cycle. Read data comes straight from the array with no output register. Because every command owns exactly one later data cycle, reads and writes can alternate on consecutive cycles with no idle cycle for bus turnaround.

A controller starts an access by holding load (`adv_ld_i` low) with all three chip selects true. With load released (`adv_ld_i` high), the block continues the current access as a four-beat burst. A deselect drops new work but lets a transfer that is already pending finish. The bidirectional data bus is split into an input, an output and an output-enable, so a pad ring or a bench can rebuild the tri-state pin.

Top module: `zbt_sram_ft`

## Requirements
- R1: After reset no access is pending, and `dq_oe_o` is low until a read command has been captured.
- R2: A command captured at edge N moves its data in the cycle between edge N and edge N+1. For a read, `dq_o` shows the addressed word and `dq_oe_o` is high in that cycle.
- R3: A write updates only the lanes whose strobe is low. Lane k is data bits [9k+8:9k] and is guarded by `bwe_n_i[k]`. The strobes are sampled with the command, and the data is sampled at the edge that ends the data cycle.
- R4: While `cken_n_i` is high, an edge captures no command, commits no write, and leaves `dq_o` and `dq_oe_o` unchanged.
- R5: If `adv_ld_i` is low and any chip select is false (`cs_a_n_i` high, `cs_b_i` low or `cs_c_n_i` high), no access starts and `dq_oe_o` is low in the next cycle. A write captured before the deselect still commits.
- R6: In the data cycle of a write, `dq_oe_o` is low.
- R7: `oe_n_i` high forces `dq_oe_o` low at once, even in a read data cycle, and `oe_n_i` low restores it without a clock edge.
- R8: A write followed directly by a read of the same address, with no idle cycle, returns the newly written word.
- R9: With `adv_ld_i` high after a started access, each edge continues in the same direction at the next address. The low two address bits step by one and wrap within the aligned group of four, `addr_i` is ignored, and the strobes are sampled anew on every beat.
- R10: `adv_ld_i` high when no burst is running (after reset or after a deselect) starts nothing, and `dq_oe_o` stays low.
- R11: For a read, the byte strobes are ignored and the whole word is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| cken_n_i | input | 1 | Active-low clock enable; high freezes the block |
| adv_ld_i | input | 1 | Low: load a new command; high: advance the burst |
| rd_wr_i | input | 1 | 1 = read, 0 = write, sampled on load |
| cs_a_n_i | input | 1 | Chip select, active low |
| cs_b_i | input | 1 | Chip select, active high |
| cs_c_n_i | input | 1 | Chip select, active low |
| addr_i | input | ADDR_W | Word address, sampled on load |
| bwe_n_i | input | 4 | Active-low lane write strobes |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dq_i | input | 36 | Write data, taken in the data cycle |
| dq_o | output | 36 | Flow-through read data |
| dq_oe_o | output | 1 | High while the block drives the data bus |

## Verification
The bench uses the default `ADDR_W` of 6, which gives 64 words. That is small enough that one run reaches both ends of a burst's wrap group and returns to addresses it wrote many cycles earlier. With a 6-bit address, a burst started at word 10 visits 10, 11, 8 and 9, so the wrap of the low two bits is observable while the upper bits stay put. The same depth lets the bench mix lane-merged writes, frozen data cycles and deselects on separate addresses and read each result back unambiguously.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [LANES-1:0] bwe_n;
  } op_t;
endpackage

// File: rtl/zbt_cmd_stage.sv
`timescale 1ns/1ps
module zbt_cmd_stage
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              adv_ld,
  input  logic              rd_wr,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bwe_n,
  output op_t               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  op_t               op_q, op_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              brst_q, brst_n;

  always_comb begin
    op_n   = op_q;
    addr_n = addr_q;
    brst_n = brst_q;
    if (ce) begin
      if (!adv_ld) begin
        if (sel) begin
          op_n.vld   = 1'b1;
          op_n.wr    = !rd_wr;
          op_n.bwe_n = bwe_n;
          addr_n     = addr;
          brst_n     = 1'b1;
        end else begin
          op_n.vld = 1'b0;
          brst_n   = 1'b0;
        end
      end else if (brst_q) begin
        op_n.vld   = 1'b1;
        op_n.bwe_n = bwe_n;
        addr_n     = {addr_q[ADDR_W-1:2], addr_q[1:0] + 2'd1};
      end else begin
        op_n.vld = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      brst_q <= 1'b0;
    end else if (ce) begin
      op_q   <= op_n;
      addr_q <= addr_n;
      brst_q <= brst_n;
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(op_q) && $stable(addr_q));

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !adv_ld && !sel |=> !op_q.vld);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !adv_ld && sel |=> op_q.vld && addr_q == $past(addr) && op_q.wr == !$past(rd_wr));

  p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce && adv_ld && op_q.vld |=> op_q.vld && addr_q[1:0] == $past(addr_q[1:0]) + 2'd1
                                 && addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce && adv_ld && !op_q.vld |=> !op_q.vld);
endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  bwe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;

    assign lane_we = we && !bwe_n[k];

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[addr] <= wdata[k*LANE_W +: LANE_W];
    end

    assign rdata[k*LANE_W +: LANE_W] = lane_mem[addr];
  end
endmodule

// File: rtl/zbt_sram_ft.sv
`timescale 1ns/1ps
module zbt_sram_ft
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cken_n_i,
  input  logic              adv_ld_i,
  input  logic              rd_wr_i,
  input  logic              cs_a_n_i,
  input  logic              cs_b_i,
  input  logic              cs_c_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        bwe_n_i,
  input  logic              oe_n_i,
  input  logic [35:0]       dq_i,
  output logic [35:0]       dq_o,
  output logic              dq_oe_o
);
  logic              ce, sel, we;
  op_t               op;
  logic [ADDR_W-1:0] op_addr;
  logic [WORD_W-1:0] rd_word;

  assign ce  = !cken_n_i;
  assign sel = !cs_a_n_i && cs_b_i && !cs_c_n_i;

  zbt_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce     (ce),
    .adv_ld (adv_ld_i),
    .rd_wr  (rd_wr_i),
    .sel    (sel),
    .addr   (addr_i),
    .bwe_n  (bwe_n_i),
    .op_o   (op),
    .addr_o (op_addr)
  );

  assign we = ce && op.vld && op.wr;

  zbt_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (we),
    .bwe_n (op.bwe_n),
    .addr  (op_addr),
    .wdata (dq_i),
    .rdata (rd_word)
  );

  assign dq_o    = rd_word;
  assign dq_oe_o = op.vld && !op.wr && !oe_n_i;

  p_write_bus_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cken_n_i && !adv_ld_i && !cs_a_n_i && cs_b_i && !cs_c_n_i && !rd_wr_i |=> !dq_oe_o);

  p_oe_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cken_n_i && $stable(oe_n_i) |=> $stable(dq_oe_o));
endmodule

// File: tb/zbt_sram_ft_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_ft_tb_top;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam logic [2:0] SEL    = 3'b010; // {cs_c_n, cs_b, cs_a_n}
  localparam logic [2:0] DES_A  = 3'b011;
  localparam logic [2:0] DES_B  = 3'b000;
  localparam logic [2:0] DES_C  = 3'b110;

  logic clk, rst_n, cken_n, adv_ld, rd_wr, cs_a_n, cs_b, cs_c_n, oe_n;
  logic [AW-1:0] addr;
  logic [3:0]    bwe_n;
  logic [35:0]   dq_i, dq_o;
  logic          dq_oe;
  int n_chk, n_bad;

  zbt_sram_ft #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cken_n_i(cken_n), .adv_ld_i(adv_ld),
    .rd_wr_i(rd_wr), .cs_a_n_i(cs_a_n), .cs_b_i(cs_b), .cs_c_n_i(cs_c_n),
    .addr_i(addr), .bwe_n_i(bwe_n), .oe_n_i(oe_n), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one cycle: set inputs, pass an edge, settle
  task automatic tick(input logic adv, input logic rw, input logic [2:0] cs,
                      input logic [AW-1:0] a, input logic [3:0] bw,
                      input logic [35:0] d, input logic ckn);
    adv_ld = adv; rd_wr = rw; {cs_c_n, cs_b, cs_a_n} = cs;
    addr = a; bwe_n = bw; dq_i = d; cken_n = ckn;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  function automatic logic [35:0] merge(input logic [35:0] o, input logic [35:0] n,
                                        input logic [3:0] bw);
    logic [35:0] r = o;
    for (int k = 0; k < 4; k++) if (!bw[k]) r[k*9 +: 9] = n[k*9 +: 9];
    return r;
  endfunction

  localparam logic [35:0] WX = 36'h9_1234_5678;
  localparam logic [35:0] WY = 36'h6_ABCD_EF01;
  localparam logic [35:0] WZ = 36'h3_0F0F_A5A5;

  task automatic t_reset();
    chk("R1 oe after reset", dq_oe, 0);
    tick(1, 1, SEL, 0, 4'hF, 0, 0);
    chk("R10 advance with no burst", dq_oe, 0);
  endtask

  task automatic t_write_read();
    tick(0, 0, SEL, 5, 4'h0, 0, 0);
    chk("R6 write data cycle bus off", dq_oe, 0);
    tick(0, 1, SEL, 5, 4'h0, WX, 0);
    chk("R2 read oe", dq_oe, 1);
    chk("R8 read after write", dq_o, WX);
  endtask

  task automatic t_lanes();
    tick(0, 0, SEL, 5, 4'b0101, 0, 0);
    tick(0, 1, SEL, 5, 4'hF, WY, 0);
    chk("R3 lane merge", dq_o, merge(WX, WY, 4'b0101));
    tick(0, 1, SEL, 5, 4'h0, 0, 0);
    chk("R11 strobes ignored on read", dq_o, merge(WX, WY, 4'b0101));
  endtask

  task automatic t_deselect();
    logic [2:0] pats [3] = '{DES_A, DES_B, DES_C};
    for (int i = 0; i < 3; i++) begin
      tick(0, 1, SEL, 5, 4'hF, 0, 0);
      chk("R2 read before deselect", dq_oe, 1);
      tick(0, 1, pats[i], 5, 4'hF, 0, 0);
      chk("R5 deselect bus off", dq_oe, 0);
      tick(1, 1, SEL, 5, 4'hF, 0, 0);
      chk("R10 advance after deselect", dq_oe, 0);
    end
    tick(0, 0, SEL, 20, 4'h0, 0, 0);
    tick(0, 1, DES_A, 0, 4'hF, WZ, 0);
    tick(0, 1, SEL, 20, 4'hF, 0, 0);
    chk("R5 pending write completes", dq_o, WZ);
  endtask

  task automatic t_oe();
    tick(0, 1, SEL, 5, 4'hF, 0, 0);
    oe_n = 1'b1; #1;
    chk("R7 oe_n forces off", dq_oe, 0);
    oe_n = 1'b0; #1;
    chk("R7 oe_n restores", dq_oe, 1);
  endtask

  task automatic t_freeze();
    tick(0, 1, SEL, 5, 4'hF, 0, 0);
    tick(0, 0, SEL, 7, 4'h0, WZ, 1);
    chk("R4 frozen oe", dq_oe, 1);
    chk("R4 frozen data", dq_o, merge(WX, WY, 4'b0101));
    tick(0, 0, SEL, 9, 4'h0, 0, 0);
    tick(0, 1, SEL, 0, 4'h0, 36'hF_FFFF_FFFF, 1);
    tick(0, 1, SEL, 9, 4'hF, WY, 0);
    chk("R4 frozen write commit", dq_o, WY);
    tick(0, 1, SEL, 7, 4'hF, 0, 0);
    chk("R4 frozen cmd ignored", dq_o === WZ ? 36'h1 : 36'h0, 36'h0);
  endtask

  task automatic t_burst();
    logic [35:0] d [4] = '{36'h1_1111_1111, 36'h2_2222_2222, 36'h3_3333_3333, 36'h4_4444_4444};
    logic [AW-1:0] seq [4] = '{6'd10, 6'd11, 6'd8, 6'd9};
    tick(0, 0, SEL, 10, 4'h0, 0, 0);
    for (int i = 1; i < 4; i++) begin
      tick(1, 1, SEL, 6'd33, 4'h0, d[i-1], 0);
      chk("R9 write burst bus off", dq_oe, 0);
    end
    tick(0, 1, SEL, 10, 4'hF, d[3], 0);
    for (int i = 0; i < 4; i++) begin
      chk($sformatf("R9 burst beat %0d addr %0d", i, seq[i]), dq_o, d[i]);
      chk("R9 burst oe", dq_oe, 1);
      if (i < 3) tick(1, 0, SEL, 6'd50, 4'h0, 0, 0);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 0; cken_n = 0; adv_ld = 0; rd_wr = 1; cs_a_n = 1; cs_b = 0; cs_c_n = 1;
    addr = '0; bwe_n = 4'hF; dq_i = '0; oe_n = 0;
    #(CLK_P*2 + CLK_P/4);
    chk("R1 oe in reset", dq_oe, 0);
    rst_n = 1;
    t_reset();
    t_write_read();
    t_lanes();
    t_deselect();
    t_oe();
    t_freeze();
    t_burst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule